// File: doc/BRIEF.md
# Dual-Channel PWM Audio DAC

The block turns a stream of signed 16-bit audio samples into two 8-bit pulse-width outputs. The upper byte of the converted sample drives one output and the lower byte drives the other. An external resistor network, outside this block, weights and sums the two pins. Both channels take their timing from one shared counter, so their periods and reload points match exactly.

The period can be edge-aligned or centre-aligned. In edge-aligned mode every pulse starts at the beginning of the period, and only its end moves as the value changes. In centre-aligned mode the counter runs up and then back down, so each pulse stays centred in a period about twice as long. The block takes exactly one sample per period. In the last clock of each period it raises a one-clock request, which is also its ready signal. A sample presented with valid in that clock becomes the pair of compare values for the next period.

An optional conditioning stage scales the sample to a quarter of full swing before the byte split. It also moves the resting point down to a low average duty. Because the scaling happens before the split, both channels are lowered together.

Top module: `pwm_dual_dac`

## Requirements
- R1: With edge-aligned mode (`mode_center`=0) in force, a period lasts 256 clocks. Number the clock after a request clock as index 0. Each output is high exactly at indices k < C, where C is that channel's compare value.
- R2: With centre-aligned mode (`mode_center`=1) in force, a period lasts 510 clocks and the counter steps 0..255 and then 254..1. Each output is high exactly at indices 256−C ≤ k ≤ 254+C, which is 2C−1 clocks centred on index 255.
- R3: With conditioning off at acceptance, the code is the sample with bit 15 inverted. `pwm_hi` takes code[15:8] and `pwm_lo` takes code[7:0].
- R4: With conditioning on at acceptance (`cond_en`=1), the code is 8192 plus the sample arithmetically shifted right by 2, which gives 0..16383. It is split into bytes as in R3.
- R5: `req` and `s_ready` are equal. They are high for exactly one clock, the last clock of every period. After reset is released, the first one falls in the 256th clock, counting the release clock as the first. A sample is taken at the clock edge that ends that clock if `s_valid` is high.
- R6: If `s_valid` is low in the request clock, both compare values from the previous period are kept.
- R7: `mode_center` is sampled only at the request clock, and `cond_en` only together with an accepted sample. Changes at other times do not alter the current period's length or pulses.
- R8: A compare value of 0 holds its output low for the whole period in either mode.
- R9: During reset and in the clock after release, both outputs and `req` are low. The compare values are 0 and edge-aligned mode is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_center | input | 1 | Mode for the next period: 0 edge-aligned, 1 centre-aligned |
| cond_en | input | 1 | Apply quarter-scale, low-duty conditioning to the accepted sample |
| s_valid | input | 1 | Sample present |
| s_data | input | 16 | Signed two's complement sample |
| s_ready | output | 1 | Sample taken at this clock edge if valid |
| req | output | 1 | One-clock request in the last clock of each period |
| pwm_hi | output | 1 | PWM for the upper code byte |
| pwm_lo | output | 1 | PWM for the lower code byte |

## Verification
The output registers are loaded from the counter's next state, so the pulse for a sample accepted in the request clock begins at index 0, the very next clock. The following request appears at index 255 in edge-aligned mode and at index 509 in centre-aligned mode. The bench drives inputs and samples outputs on the falling edge. Each period it compares every output level against the level expected for that index, and it checks that `req` appears only at the final index. Inputs are deliberately disturbed at index 0 and index 10, so any sampling outside the request clock would show up in that same period.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTER = 1'b1
  } pwm_mode_e;
endpackage

// File: rtl/pwm_dac_cond.sv
module pwm_dac_cond #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] smp,
  input  logic          cond_en,
  output logic [SW-1:0] code
);
  localparam logic [SW-1:0] QUARTER = SW'(1) << (SW - 3);
  localparam logic [SW-1:0] SIGNBIT = SW'(1) << (SW - 1);

  logic signed [SW-1:0] s_signed;
  logic signed [SW-1:0] s_scaled;

  always_comb begin
    s_signed = $signed(smp);
    s_scaled = s_signed >>> 2;
    if (cond_en) code = QUARTER + $unsigned(s_scaled);
    else         code = smp ^ SIGNBIT;
  end
endmodule

// File: rtl/pwm_dac_timebase.sv
module pwm_dac_timebase
  import pwm_dac_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  pwm_mode_e     mode_in,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output pwm_mode_e     mode_q,
  output pwm_mode_e     mode_d,
  output logic          last_q
);
  localparam logic [CW-1:0] TOP = '1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic down_q, down_d, last_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    mode_d = mode_q;
    if (last_q) begin
      cnt_d  = '0;
      down_d = 1'b0;
      mode_d = mode_in;
    end else if (mode_q == MODE_CENTER) begin
      if (!down_q) begin
        if (cnt_q == TOP) begin
          down_d = 1'b1;
          cnt_d  = TOP - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end else begin
      cnt_d = cnt_q + ONE;
    end
    if (mode_d == MODE_CENTER) last_d = down_d && (cnt_d == ONE);
    else                       last_d = (cnt_d == TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      mode_q <= MODE_EDGE;
      last_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      mode_q <= mode_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/pwm_dac_channel.sv
module pwm_dac_channel
  import pwm_dac_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] cnt_d,
  input  pwm_mode_e     mode_d,
  output logic [CW-1:0] cmp_q,
  output logic          pwm_q
);
  logic [CW-1:0] cmp_d;
  logic [CW:0]   sum;
  logic          hit;

  always_comb begin
    cmp_d = load ? load_val : cmp_q;
    sum   = {1'b0, cnt_d} + {1'b0, cmp_d};
    if (mode_d == MODE_CENTER) hit = sum[CW];
    else                       hit = (cnt_d < cmp_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      pwm_q <= hit;
    end
  end
endmodule

// File: rtl/pwm_dual_dac.sv
module pwm_dual_dac
  import pwm_dac_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_center,
  input  logic                 cond_en,
  input  logic                 s_valid,
  input  logic [2*CNT_W-1:0]   s_data,
  output logic                 s_ready,
  output logic                 req,
  output logic                 pwm_hi,
  output logic                 pwm_lo
);
  localparam int SMP_W = 2 * CNT_W;
  localparam int NCH   = 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  pwm_mode_e        mode_q, mode_d, mode_in;
  logic             last_q, load;
  logic [SMP_W-1:0] code;
  logic [CNT_W-1:0] cmp_vec [NCH];
  logic [NCH-1:0]   pwm_vec;

  assign mode_in = pwm_mode_e'(mode_center);
  assign load    = last_q && s_valid;

  pwm_dac_cond #(.SW(SMP_W)) u_cond (
    .smp(s_data), .cond_en(cond_en), .code(code)
  );

  pwm_dac_timebase #(.CW(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .mode_in(mode_in),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .mode_q(mode_q), .mode_d(mode_d),
    .last_q(last_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_dac_channel #(.CW(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .load(load),
      .load_val(code[ch*CNT_W +: CNT_W]),
      .cnt_d(cnt_d), .mode_d(mode_d),
      .cmp_q(cmp_vec[ch]), .pwm_q(pwm_vec[ch])
    );
  end

  assign s_ready = last_q;
  assign req     = last_q;
  assign pwm_hi  = pwm_vec[1];
  assign pwm_lo  = pwm_vec[0];
endmodule

// File: rtl/pwm_dual_dac_chk.sv
module pwm_dual_dac_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          s_ready,
  input logic          s_valid,
  input logic          pwm_hi,
  input logic          pwm_lo,
  input logic          mode_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cmp_hi,
  input logic [CW-1:0] cmp_lo
);
  localparam logic [CW-1:0] TOP = '1;

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  p_ready_req_r5: assert property (@(posedge clk) disable iff (rst)
    s_ready == req);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (req && !s_valid) |=> ($stable(cmp_hi) && $stable(cmp_lo)));
  p_mid_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(cmp_hi) && $stable(cmp_lo) && $stable(mode_q)));
  p_zero_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (!req && cmp_hi == '0) |=> !pwm_hi);
  p_zero_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (!req && cmp_lo == '0) |=> !pwm_lo);
  p_fast_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && cnt_q == TOP) |=> (cnt_q == '0));
  p_center_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q && cnt_q == TOP) |=> (cnt_q == TOP - CW'(1)));
endmodule

bind pwm_dual_dac pwm_dual_dac_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .s_ready(s_ready), .s_valid(s_valid),
  .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .mode_q(mode_q), .cnt_q(cnt_q),
  .cmp_hi(cmp_vec[1]), .cmp_lo(cmp_vec[0])
);

// File: tb/pwm_dual_dac_test.sv
`timescale 1ns/1ps
module pwm_dual_dac_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_center = 1'b0;
  logic        cond_en = 1'b0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready, req, pwm_hi, pwm_lo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ehi = 0;
  int elo = 0;

  always #2.5 clk = ~clk;

  pwm_dual_dac uut (
    .clk(clk), .rst(rst), .mode_center(mode_center), .cond_en(cond_en),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .req(req),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [15:0] d, input bit cond);
    logic signed [15:0] s;
    logic [15:0] r;
    s = $signed(d);
    if (cond) r = 16'd8192 + $unsigned(s >>> 2);
    else      r = d ^ 16'h8000;
    return int'(r);
  endfunction

  function automatic bit exp_level(input bit center, input int k, input int c);
    if (center) return (c != 0) && (k >= 256 - c) && (k <= 254 + c);
    return k < c;
  endfunction

  function automatic int exp_high(input bit center, input int c);
    if (c == 0) return 0;
    return center ? 2 * c - 1 : c;
  endfunction

  function automatic string tag_for(input bit center, input bit valid, input bit cond, input int c);
    string t;
    t = center ? "R2" : "R1";
    if (c == 0) t = {t, "/R8"};
    if (!valid) t = {t, "/R6"};
    else if (cond) t = {t, "/R4"};
    else t = {t, "/R3"};
    return t;
  endfunction

  // Called at the falling edge of a request clock.
  task automatic run_period(input bit valid, input logic [15:0] d, input bit center, input bit cond);
    int n, bad_h, bad_l, bad_r, hc_h, hc_l, code;
    s_valid = valid;
    s_data = d;
    mode_center = center;
    cond_en = cond;
    if (valid) begin
      code = exp_code(d, cond);
      ehi = (code >> 8) & 255;
      elo = code & 255;
    end
    n = center ? 510 : 256;
    bad_h = 0; bad_l = 0; bad_r = 0; hc_h = 0; hc_l = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) begin
        s_valid = 1'b0;
        s_data = 16'($urandom);
      end
      if (k == 10) begin
        mode_center = ~center;
        cond_en = ~cond;
        s_valid = 1'b1;
      end
      if (pwm_hi !== exp_level(center, k, ehi)) bad_h++;
      if (pwm_lo !== exp_level(center, k, elo)) bad_l++;
      if (pwm_hi === 1'b1) hc_h++;
      if (pwm_lo === 1'b1) hc_l++;
      if (req !== (k == n - 1) || s_ready !== req) bad_r++;
    end
    s_valid = 1'b0;
    chk(bad_h == 0, tag_for(center, valid, cond, ehi), hc_h, exp_high(center, ehi));
    chk(bad_l == 0, tag_for(center, valid, cond, elo), hc_l, exp_high(center, elo));
    chk(bad_r == 0, "R5/R7 request position", bad_r, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(pwm_hi === 1'b0 && pwm_lo === 1'b0, "R9 outputs in reset", int'(pwm_hi | pwm_lo), 0);
    chk(req === 1'b0 && s_ready === 1'b0, "R9 req in reset", int'(req), 0);
    rst = 1'b0;
    n = 0;
    while (req !== 1'b1 && n < 400) begin
      if (pwm_hi !== 1'b0 || pwm_lo !== 1'b0) n = 1000;
      @(negedge clk);
      n++;
    end
    chk(n == 255, "R5/R8/R9 first request after reset", n, 255);

    // directed corner cases
    run_period(1'b1, 16'h8000, 1'b0, 1'b0); // code 0: both low
    run_period(1'b1, 16'h7FFF, 1'b0, 1'b0); // full scale 255/255
    run_period(1'b1, 16'h7FFF, 1'b1, 1'b0);
    run_period(1'b1, 16'h0000, 1'b1, 1'b0); // 0x8000: hi 128, lo 0
    run_period(1'b0, 16'h1234, 1'b1, 1'b0); // hold previous
    run_period(1'b1, 16'h7FFF, 1'b0, 1'b1); // 0x3FFF
    run_period(1'b1, 16'h8000, 1'b1, 1'b1); // 0
    run_period(1'b1, 16'hFFFF, 1'b0, 1'b1); // 8191 = 0x1FFF
    run_period(1'b0, 16'h0000, 1'b0, 1'b0); // hold in fast mode
    run_period(1'b1, 16'h8001, 1'b1, 1'b0); // code 1: single-clock pulses

    // constrained random
    for (int i = 0; i < 36; i++) begin
      run_period(($urandom % 8) != 0, 16'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule